// File: doc/BRIEF.md
# Byte-Exact Word-Bus Access Sequencer

This block sits between a processor's unaligned-access path and a 16-bit I/O bus on which a read can change device state and a byte store is not the same thing as reading a word, merging a byte and writing the word back. It takes one request: a physical address, a length of one to three bytes, a direction and, for stores, right-justified data. It then runs the smallest set of word reads, word writes and byte writes that touches exactly the addressed bytes. Every bus operation carries its own address and masked data.

Each bus transaction is offered with `bus_req` and held until the bus answers with `bus_ack` or `bus_err`. The next transaction starts in the following cycle. For loads, the words that come back are packed into a 32-bit result with the same lane layout as an aligned I/O read. A one-cycle `rsp_done` follows the last answer. An error on any transaction cancels the rest of the sequence and is reported with `rsp_err` in the `rsp_done` cycle.

The caller keeps the address offset plus the length within four bytes and never sends a length of zero.

Top module: `wbus_split_seq`

## Requirements
- R1: For a load whose length plus address bit 0 is at most 2, exactly one word read (`bus_write`=0, `bus_byte`=0) is issued, at the request address.
- R2: When a load uses one word read, `rsp_rdata` holds that word in bits 31:16 with bits 15:0 zero if address bit 1 is set. Otherwise it holds the word in bits 15:0 with bits 31:16 zero.
- R3: Any other load issues exactly two word reads, first at the address and then at address+2. `rsp_rdata` is {second word, first word}.
- R4: A one-byte store at any offset issues exactly one byte write (`bus_write`=1, `bus_byte`=1) at the address. The byte is `req_wdata[7:0]` on `bus_wdata[7:0]`, and `bus_wdata[15:8]` is zero.
- R5: A two-byte store at an even address issues one word write of `req_wdata[15:0]`. At an odd address it issues two byte writes: `req_wdata[7:0]` at the address, then `req_wdata[15:8]` at address+1.
- R6: A three-byte store at an odd address issues a byte write of `req_wdata[7:0]` at the address, then a word write of `req_wdata[23:8]` at address+1.
- R7: A three-byte store at an even address issues a word write of `req_wdata[15:0]` at the address, then a byte write of `req_wdata[23:16]` at address+2.
- R8: While `bus_req` is high and neither `bus_ack` nor `bus_err` is high, the address, data, direction and size stay unchanged. A store request never produces a bus read.
- R9: `rsp_done` is high for exactly one cycle, the cycle after the final acknowledge. `req_busy` is high from the cycle after the request is accepted through the `rsp_done` cycle, and low after it.
- R10: `bus_err` (which wins over a simultaneous `bus_ack`) ends the sequence. No further transaction is issued, and the next cycle shows `rsp_done` and `rsp_err` high with `bus_req` low.
- R11: `req_start` while `req_busy` is high is ignored. It changes neither the running sequence nor the number of transactions.
- R12: After reset, `bus_req`, `rsp_done`, `rsp_err` and `req_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_start | input | 1 | Starts a request when the block is idle |
| req_addr | input | AW | Physical byte address of the request |
| req_len | input | 2 | Byte count, 1 to 3 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data, right-justified |
| req_busy | output | 1 | A sequence is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | With rsp_done: the sequence was cut short by a bus error |
| rsp_rdata | output | 32 | Load result in aligned-read lane layout |
| bus_req | output | 1 | Bus transaction offered |
| bus_addr | output | AW | Bus transaction byte address |
| bus_write | output | 1 | 1 = write, 0 = word read |
| bus_byte | output | 1 | 1 = byte write, 0 = word transfer |
| bus_wdata | output | 16 | Write data, byte in bits 7:0 for byte writes |
| bus_rdata | input | 16 | Read data returned with bus_ack |
| bus_ack | input | 1 | Transaction completed |
| bus_err | input | 1 | Transaction failed |

## Verification
Two pairs of events can meet in one cycle. The first is an acknowledge and an error on the same transaction. The bench raises `bus_ack` and `bus_err` together on the first or the second transaction of a sequence, and expects the error to win: the transaction count stops there, and `rsp_err` appears with `rsp_done`. The second is a new `req_start` arriving while a stalled transaction is still waiting for its answer. The bench raises it with a different address in the middle of a read pair, then checks that only the original two reads at the original addresses appear and that the bus stays quiet after `rsp_done`.

// File: rtl/wbseq_pkg.sv
// Shared types for the word-bus access sequencer.
// Assumes at most two bus transactions per request.
package wbseq_pkg;
    localparam int NSLOT = 2;
    localparam int IDXW  = $clog2(NSLOT);

    typedef enum logic [1:0] {
        OP_RD_WORD = 2'd0,
        OP_WR_WORD = 2'd1,
        OP_WR_BYTE = 2'd2
    } bus_op_e;

    // One planned bus transaction: operation, masked data, byte offset from base
    typedef struct packed {
        bus_op_e     op;
        logic [15:0] data;
        logic [1:0]  offs;
    } xfer_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wbseq_plan.sv
// Transaction planner: turns offset, length and direction into one or two
// bus transactions with masked data. Purely combinational.
// Assumes offset + length <= 4 and length != 0 (length 0 is planned as 1).
module wbseq_plan
    import wbseq_pkg::*;
(
    input  logic [1:0]              addr_lo,
    input  logic [1:0]              len,
    input  logic                    is_write,
    input  logic [31:0]             wdata,
    output xfer_t [NSLOT-1:0]       plan,
    output logic                    two_step
);
    // Select the transaction list for this request shape
    always_comb begin
        plan     = '0;
        two_step = 1'b0;
        if (!is_write) begin
            two_step = ({1'b0, len} + {2'b00, addr_lo[0]}) > 3'd2;
            plan[0]  = '{op: OP_RD_WORD, data: 16'h0000, offs: 2'd0};
            plan[1]  = '{op: OP_RD_WORD, data: 16'h0000, offs: 2'd2};
        end else begin
            case (len)
                2'd2: begin
                    if (addr_lo[0]) begin
                        two_step = 1'b1;
                        plan[0]  = '{op: OP_WR_BYTE, data: {8'h00, wdata[7:0]},  offs: 2'd0};
                        plan[1]  = '{op: OP_WR_BYTE, data: {8'h00, wdata[15:8]}, offs: 2'd1};
                    end else begin
                        plan[0]  = '{op: OP_WR_WORD, data: wdata[15:0], offs: 2'd0};
                    end
                end
                2'd3: begin
                    two_step = 1'b1;
                    if (addr_lo[0]) begin
                        plan[0] = '{op: OP_WR_BYTE, data: {8'h00, wdata[7:0]}, offs: 2'd0};
                        plan[1] = '{op: OP_WR_WORD, data: wdata[23:8],         offs: 2'd1};
                    end else begin
                        plan[0] = '{op: OP_WR_WORD, data: wdata[15:0],          offs: 2'd0};
                        plan[1] = '{op: OP_WR_BYTE, data: {8'h00, wdata[23:16]}, offs: 2'd2};
                    end
                end
                default: begin
                    plan[0] = '{op: OP_WR_BYTE, data: {8'h00, wdata[7:0]}, offs: 2'd0};
                end
            endcase
        end
    end
endmodule

// File: rtl/wbseq_ctrl.sv
// Sequence controller: accepts a request when idle, steps through the
// planned transactions one acknowledge at a time, aborts on bus error and
// produces a one-cycle done. Assumes the bus answers each offered transaction.
module wbseq_ctrl
    import wbseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            two_step_in,
    input  logic            bus_ack,
    input  logic            bus_err,
    output logic            load,
    output logic            issue,
    output logic [IDXW-1:0] idx,
    output logic            cap,
    output logic            done,
    output logic            err_out,
    output logic            busy
);
    seq_state_e      state;
    logic [IDXW-1:0] last_idx;
    logic            err_q;

    // Decode control strobes from the current state
    always_comb begin
        load    = (state == S_IDLE) && start;
        issue   = (state == S_RUN);
        cap     = (state == S_RUN) && bus_ack && !bus_err;
        done    = (state == S_DONE);
        err_out = (state == S_DONE) && err_q;
        busy    = (state != S_IDLE);
    end

    // State, step index and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            last_idx <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state    <= S_RUN;
                        idx      <= '0;
                        last_idx <= two_step_in ? IDXW'(1) : IDXW'(0);
                        err_q    <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (bus_err) begin
                        state <= S_DONE;
                        err_q <= 1'b1;
                    end else if (bus_ack) begin
                        if (idx == last_idx) state <= S_DONE;
                        else                 idx   <= idx + IDXW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: an unanswered transaction keeps being offered with the same step
    p_hold_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !bus_ack && !bus_err |=> issue && $stable(idx));

    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an error ends the sequence in the next cycle with the flag set
    p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue && bus_err |=> !issue && done && err_out);
endmodule

// File: rtl/wbseq_gather.sv
// Read-data gather: captures each acknowledged read word into its slot and
// places the result in aligned-read lane layout. Cleared at each new request.
module wbseq_gather
    import wbseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cap,
    input  logic [IDXW-1:0] cap_idx,
    input  logic [15:0]     word_in,
    input  logic            two_step,
    input  logic            hi_half,
    output logic [31:0]     rdata
);
    logic [15:0] word_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Hold the word returned by transaction g
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                     word_q[g] <= '0;
            else if (cap && cap_idx == IDXW'(g))     word_q[g] <= word_in;
        end
    end

    // Place the captured words in the 32-bit result
    always_comb begin
        if (two_step)     rdata = {word_q[1], word_q[0]};
        else if (hi_half) rdata = {word_q[0], 16'h0000};
        else              rdata = {16'h0000, word_q[0]};
    end
endmodule

// File: rtl/wbus_split_seq.sv
// Top of the word-bus access sequencer. Latches the planned transactions of
// an accepted request and drives them onto the bus one at a time.
// Assumes offset + length <= 4, length != 0, and one request at a time.
module wbus_split_seq
    import wbseq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_len,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    output logic          req_busy,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [31:0]   rsp_rdata,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic          bus_byte,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err
);
    xfer_t [NSLOT-1:0] plan_d, plan_q;
    logic              two_d, two_q;
    logic [AW-1:0]     base_q;
    logic              hi_q, wr_q;
    logic              load, issue, cap;
    logic [IDXW-1:0]   idx;
    xfer_t             cur;

    wbseq_plan i_plan (
        .addr_lo  (req_addr[1:0]),
        .len      (req_len),
        .is_write (req_write),
        .wdata    (req_wdata),
        .plan     (plan_d),
        .two_step (two_d)
    );

    wbseq_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_start),
        .two_step_in (two_d),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .load        (load),
        .issue       (issue),
        .idx         (idx),
        .cap         (cap),
        .done        (rsp_done),
        .err_out     (rsp_err),
        .busy        (req_busy)
    );

    wbseq_gather i_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .cap      (cap),
        .cap_idx  (idx),
        .word_in  (bus_rdata),
        .two_step (two_q),
        .hi_half  (hi_q),
        .rdata    (rsp_rdata)
    );

    // Latch the plan and request context when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= '0;
            two_q  <= 1'b0;
            base_q <= '0;
            hi_q   <= 1'b0;
            wr_q   <= 1'b0;
        end else if (load) begin
            plan_q <= plan_d;
            two_q  <= two_d;
            base_q <= req_addr;
            hi_q   <= req_addr[1];
            wr_q   <= req_write;
        end
    end

    // Drive the current transaction onto the bus
    always_comb begin
        cur       = plan_q[idx];
        bus_req   = issue;
        bus_addr  = issue ? base_q + AW'(cur.offs) : '0;
        bus_write = issue && (cur.op != OP_RD_WORD);
        bus_byte  = issue && (cur.op == OP_WR_BYTE);
        bus_wdata = (issue && cur.op != OP_RD_WORD) ? cur.data : 16'h0000;
    end

    // R1: caller contract on accepted requests
    p_legal_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_start && !req_busy |-> req_len != 2'd0 &&
        ({1'b0, req_addr[1:0]} + {1'b0, req_len}) <= 3'd4);

    // R8: bus fields stay put while a transaction waits
    p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_err |=>
        $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write) && $stable(bus_byte));

    // R8: a store never reads the bus
    p_no_rmw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && wr_q |-> bus_write);

    // R12: no bus activity while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> !bus_req && !rsp_done);
endmodule

// File: tb/test_wbus_split_seq.sv
`timescale 1ns/1ps
module test_wbus_split_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_len = 2'd1;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          req_busy, rsp_done, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          bus_req, bus_write, bus_byte;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;

    int vectors = 0;
    int fails   = 0;

    // Transaction log of the last request
    int            n_seen;
    logic          lg_w   [4];
    logic          lg_b   [4];
    logic [AW-1:0] lg_a   [4];
    logic [15:0]   lg_d   [4];
    logic          stable_bad, got_done, got_err, req_low_at_done;
    logic [31:0]   got_rdata;

    always #10 clk = ~clk;

    wbus_split_seq #(.AW(AW)) i_wbus_split_seq (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
        .req_busy(req_busy), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    function automatic logic [15:0] pat(input logic [AW-1:0] a);
        return {~a[7:0], a[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one request, answering each transaction after 'hold' wait cycles;
    // the transaction numbered err_at gets ack and err together.
    task automatic do_req(input logic [AW-1:0] a, input logic [1:0] l, input logic w,
                          input logic [31:0] d, input int hold, input int err_at,
                          input bit poke);
        n_seen = 0; stable_bad = 0; got_done = 0; got_err = 0; got_rdata = '0;
        req_low_at_done = 0;
        @(negedge clk);
        req_start = 1; req_addr = a; req_len = l; req_write = w; req_wdata = d;
        @(negedge clk);
        req_start = 0;
        for (int guard = 0; guard < 40 && !got_done; guard++) begin
            if (rsp_done) begin
                got_done = 1; got_err = rsp_err; got_rdata = rsp_rdata;
                req_low_at_done = !bus_req;
            end else if (bus_req && n_seen < 4) begin
                lg_w[n_seen] = bus_write; lg_b[n_seen] = bus_byte;
                lg_a[n_seen] = bus_addr;  lg_d[n_seen] = bus_wdata;
                for (int h = 0; h < hold; h++) begin
                    if (poke && h == 0) begin
                        req_start = 1; req_addr = 16'h3F0; req_len = 2'd1; req_write = 1;
                    end
                    @(negedge clk);
                    req_start = 0;
                    if (!bus_req || bus_addr !== lg_a[n_seen] || bus_wdata !== lg_d[n_seen] ||
                        bus_write !== lg_w[n_seen] || bus_byte !== lg_b[n_seen])
                        stable_bad = 1;
                end
                bus_rdata = pat(bus_addr);
                bus_ack = 1;
                if (n_seen == err_at) bus_err = 1;
                n_seen++;
                @(negedge clk);
                bus_ack = 0; bus_err = 0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R9 done seen", 32'(got_done), 32'd1);
        @(negedge clk);
        chk("R9 done one cycle", 32'(rsp_done), 32'd0);
        chk("R9 busy clear", 32'(req_busy), 32'd0);
    endtask

    task automatic exp_x(input string tag, input int i, input logic w, input logic b,
                         input logic [AW-1:0] a, input logic [15:0] d);
        chk({tag, " dir"},  32'(lg_w[i]), 32'(w));
        chk({tag, " size"}, 32'(lg_b[i]), 32'(b));
        chk({tag, " addr"}, 32'(lg_a[i]), 32'(a));
        if (w) chk({tag, " data"}, 32'(lg_d[i]), 32'(d));
    endtask

    task automatic t_reset;
        chk("R12 bus_req", 32'(bus_req), 32'd0);
        chk("R12 done",    32'(rsp_done), 32'd0);
        chk("R12 err",     32'(rsp_err), 32'd0);
        chk("R12 busy",    32'(req_busy), 32'd0);
    endtask

    task automatic t_read_single;
        do_req(16'h0100, 2'd2, 0, 0, 0, 9, 0);
        chk("R1 count even word", n_seen, 1);
        exp_x("R1 even word", 0, 0, 0, 16'h0100, 0);
        chk("R2 low half", got_rdata, {16'h0000, pat(16'h0100)});
        do_req(16'h0103, 2'd1, 0, 0, 1, 9, 0);
        chk("R1 count byte3", n_seen, 1);
        exp_x("R1 byte3", 0, 0, 0, 16'h0103, 0);
        chk("R2 high half", got_rdata, {pat(16'h0103), 16'h0000});
        do_req(16'h0102, 2'd2, 0, 0, 0, 9, 0);
        chk("R1 count word2", n_seen, 1);
        chk("R2 high word2", got_rdata, {pat(16'h0102), 16'h0000});
    endtask

    task automatic t_read_double;
        do_req(16'h0101, 2'd2, 0, 0, 0, 9, 0);
        chk("R3 count odd word", n_seen, 2);
        exp_x("R3 first", 0, 0, 0, 16'h0101, 0);
        exp_x("R3 second", 1, 0, 0, 16'h0103, 0);
        chk("R3 data odd word", got_rdata, {pat(16'h0103), pat(16'h0101)});
        do_req(16'h0104, 2'd3, 0, 0, 2, 9, 0);
        chk("R3 count tri", n_seen, 2);
        chk("R3 data tri", got_rdata, {pat(16'h0106), pat(16'h0104)});
    endtask

    task automatic t_write_byte;
        do_req(16'h0203, 2'd1, 1, 32'hAABBCCDD, 0, 9, 0);
        chk("R4 count", n_seen, 1);
        exp_x("R4 byte", 0, 1, 1, 16'h0203, 16'h00DD);
        do_req(16'h0200, 2'd1, 1, 32'h12345678, 0, 9, 0);
        chk("R4 count off0", n_seen, 1);
        exp_x("R4 byte off0", 0, 1, 1, 16'h0200, 16'h0078);
    endtask

    task automatic t_write_word;
        do_req(16'h0202, 2'd2, 1, 32'hAABBCCDD, 0, 9, 0);
        chk("R5 count even", n_seen, 1);
        exp_x("R5 even word", 0, 1, 0, 16'h0202, 16'hCCDD);
        do_req(16'h0201, 2'd2, 1, 32'hAABBCCDD, 0, 9, 0);
        chk("R5 count odd", n_seen, 2);
        exp_x("R5 odd first", 0, 1, 1, 16'h0201, 16'h00DD);
        exp_x("R5 odd second", 1, 1, 1, 16'h0202, 16'h00CC);
    endtask

    task automatic t_write_tri;
        do_req(16'h0301, 2'd3, 1, 32'hFF123456, 0, 9, 0);
        chk("R6 count", n_seen, 2);
        exp_x("R6 byte", 0, 1, 1, 16'h0301, 16'h0056);
        exp_x("R6 word", 1, 1, 0, 16'h0302, 16'h1234);
        do_req(16'h0300, 2'd3, 1, 32'hFF123456, 0, 9, 0);
        chk("R7 count", n_seen, 2);
        exp_x("R7 word", 0, 1, 0, 16'h0300, 16'h3456);
        exp_x("R7 byte", 1, 1, 1, 16'h0302, 16'h0012);
    endtask

    task automatic t_stall;
        do_req(16'h0401, 2'd3, 1, 32'h00ABCDEF, 3, 9, 0);
        chk("R8 held stable", 32'(stable_bad), 32'd0);
        chk("R8 no read on store", 32'(!lg_w[0] || !lg_w[1]), 32'd0);
        chk("R8 count", n_seen, 2);
    endtask

    task automatic t_error;
        do_req(16'h0501, 2'd3, 1, 32'h00ABCDEF, 0, 0, 0);
        chk("R10 stop after first", n_seen, 1);
        chk("R10 err flag", 32'(got_err), 32'd1);
        chk("R10 bus idle at done", 32'(req_low_at_done), 32'd1);
        do_req(16'h0505, 2'd3, 0, 0, 1, 1, 0);
        chk("R10 second err count", n_seen, 2);
        chk("R10 second err flag", 32'(got_err), 32'd1);
        do_req(16'h0500, 2'd1, 0, 0, 0, 9, 0);
        chk("R10 flag clears", 32'(got_err), 32'd0);
    endtask

    task automatic t_busy_start;
        do_req(16'h0601, 2'd2, 0, 0, 2, 9, 1);
        chk("R11 count", n_seen, 2);
        exp_x("R11 first", 0, 0, 0, 16'h0601, 0);
        exp_x("R11 second", 1, 0, 0, 16'h0603, 0);
        chk("R11 stable", 32'(stable_bad), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 bus quiet after", 32'(bus_req), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_single();
        t_read_double();
        t_write_byte();
        t_write_word();
        t_write_tri();
        t_stall();
        t_error();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule